// File: doc/BRIEF.md
# Circular Return-Address Stack

This block keeps the return addresses of a small processor core. Each entry holds a full 13-bit program counter. The core pulses `push_i` with the current program counter when it takes a subroutine call or an interrupt branch. It pulses `pop_i` when it executes any of its return-type instructions: plain return, return carrying a literal, or return from interrupt. The block decides nothing about when these happen; it only moves its pointer and stores entries.

The storage has eight entries, and software cannot see it: it is mapped into neither program nor data memory. The pointer cannot be read or written from outside. The buffer is circular and reports nothing. A ninth nested push silently replaces the oldest entry, and a pop with nothing pushed simply wraps the pointer and returns whatever that slot holds. The registered output `top_o` shows the address most recently pushed, or the address most recently popped, which is the return target.

Top module: `callret_stack`

## Requirements
- R1: While `rst` is high at a rising edge, the pointer goes to slot 0 and `top_o` goes to 0 at that edge. Reset does not clear the stored entries.
- R2: A push stores `push_addr_i` in the slot at the pointer and then advances the pointer by one, wrapping from 7 to 0. From the edge that takes the push, `top_o` equals the pushed address.
- R3: A pop (with `pop_i` high and `push_i` low) moves the pointer back by one, wrapping from 0 to 7. From that edge, `top_o` shows the slot the pointer now selects. Up to eight nested pushes are therefore returned in reverse order.
- R4: After nine pushes V0..V8, the ninth has overwritten V0. Eight pops then return V8, V7, V6, V5, V4, V3, V2, V1, and a further pop returns V8 again. No flag or other output reveals the overflow.
- R5: In a cycle with neither `push_i` nor `pop_i`, `top_o` and the pointer do not change.
- R6: When `push_i` and `pop_i` are both high, only the push happens and the pop is dropped. The next pop then returns the address that was pushed in that cycle.
- R7: A pop right after reset wraps the pointer to slot 7 and shows the contents that slot held before the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| push_i | input | 1 | Store `push_addr_i` and advance the pointer |
| push_addr_i | input | 13 | Return address to store |
| pop_i | input | 1 | Step the pointer back and present that entry |
| top_o | output | 13 | Last pushed or last popped address |

## Verification
The hardest case to reach from the ports is the wrap: an entry overwritten by the ninth push, followed by a pointer that runs back past slot 0 into slot 7. The bench pushes nine distinct addresses, pops ten times, and checks each popped value against the order it predicts. A second hard case is a pop straight after reset. It exposes storage that reset left untouched, so the bench fills slot 7 before asserting reset and then pops. The dropped pop in a push-and-pop cycle is made visible through the value returned by the following pop.

// File: rtl/callret_pkg.sv
package callret_pkg;

    localparam int unsigned CR_DEPTH  = 8;
    localparam int unsigned CR_ADDR_W = 13;

    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_PUSH = 2'd1,
        OP_POP  = 2'd2
    } stack_op_e;

    // Push wins over pop when both strobes arrive together.
    function automatic stack_op_e decode_op(input logic push, input logic pop);
        if (push) begin
            return OP_PUSH;
        end else if (pop) begin
            return OP_POP;
        end
        return OP_IDLE;
    endfunction

endpackage

// File: rtl/callret_ptr.sv
module callret_ptr
    import callret_pkg::*;
#(
    parameter int unsigned DEPTH = CR_DEPTH,
    localparam int unsigned PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  stack_op_e        op,
    output logic [PTR_W-1:0] ptr_q,
    output logic [PTR_W-1:0] below_idx
);

    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [PTR_W-1:0] above_idx;

    always_comb begin
        above_idx = (ptr_q == LAST) ? '0 : ptr_q + PTR_W'(1);
        below_idx = (ptr_q == '0) ? LAST : ptr_q - PTR_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else begin
            unique case (op)
                OP_PUSH: ptr_q <= above_idx;
                OP_POP:  ptr_q <= below_idx;
                default: ptr_q <= ptr_q;
            endcase
        end
    end

endmodule

// File: rtl/callret_bank.sv
module callret_bank #(
    parameter int unsigned DEPTH  = 8,
    parameter int unsigned ADDR_W = 13,
    localparam int unsigned PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [PTR_W-1:0]  wr_idx,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic [PTR_W-1:0]  rd_idx,
    output logic [ADDR_W-1:0] rd_data
);

    logic [ADDR_W-1:0] slot_q [DEPTH];

    // Entries have no reset: their contents survive a reset.
    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (we && (wr_idx == PTR_W'(s))) begin
                slot_q[s] <= wr_data;
            end
        end
    end

    assign rd_data = slot_q[rd_idx];

endmodule

// File: rtl/callret_out.sv
module callret_out
    import callret_pkg::*;
#(
    parameter int unsigned ADDR_W = CR_ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  stack_op_e         op,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic [ADDR_W-1:0] pop_data,
    output logic [ADDR_W-1:0] top_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            top_q <= '0;
        end else begin
            unique case (op)
                OP_PUSH: top_q <= push_addr;
                OP_POP:  top_q <= pop_data;
                default: top_q <= top_q;
            endcase
        end
    end

endmodule

// File: rtl/callret_stack.sv
module callret_stack
    import callret_pkg::*;
#(
    parameter int unsigned DEPTH  = CR_DEPTH,
    parameter int unsigned ADDR_W = CR_ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push_i,
    input  logic [ADDR_W-1:0] push_addr_i,
    input  logic              pop_i,
    output logic [ADDR_W-1:0] top_o
);

    localparam int unsigned PTR_W = $clog2(DEPTH);

    stack_op_e         op;
    logic [PTR_W-1:0]  ptr_q;
    logic [PTR_W-1:0]  below_idx;
    logic [ADDR_W-1:0] pop_data;

    assign op = decode_op(push_i, pop_i);

    callret_ptr #(.DEPTH(DEPTH)) u_ptr (
        .clk       (clk),
        .rst       (rst),
        .op        (op),
        .ptr_q     (ptr_q),
        .below_idx (below_idx)
    );

    callret_bank #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_bank (
        .clk     (clk),
        .we      (op == OP_PUSH),
        .wr_idx  (ptr_q),
        .wr_data (push_addr_i),
        .rd_idx  (below_idx),
        .rd_data (pop_data)
    );

    callret_out #(.ADDR_W(ADDR_W)) u_out (
        .clk       (clk),
        .rst       (rst),
        .op        (op),
        .push_addr (push_addr_i),
        .pop_data  (pop_data),
        .top_q     (top_o)
    );

endmodule

// File: rtl/callret_stack_chk.sv
module callret_stack_chk #(
    parameter int unsigned DEPTH  = 8,
    parameter int unsigned ADDR_W = 13,
    localparam int unsigned PTR_W = $clog2(DEPTH)
) (
    input logic              clk,
    input logic              rst,
    input logic              push_i,
    input logic [ADDR_W-1:0] push_addr_i,
    input logic              pop_i,
    input logic [ADDR_W-1:0] top_o,
    input logic [PTR_W-1:0]  ptr
);

    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    // R1
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (ptr == '0) && (top_o == '0));

    // R2
    a_r2_push_shows_addr: assert property (@(posedge clk) disable iff (rst)
        push_i |=> top_o == $past(push_addr_i));

    // R2
    a_r2_push_advances: assert property (@(posedge clk) disable iff (rst)
        push_i |=> ptr == (($past(ptr) == LAST) ? '0 : $past(ptr) + PTR_W'(1)));

    // R3
    a_r3_pop_retreats: assert property (@(posedge clk) disable iff (rst)
        (pop_i && !push_i) |=> ptr == (($past(ptr) == '0) ? LAST : $past(ptr) - PTR_W'(1)));

    // R3
    a_r3_pop_returns_push: assert property (@(posedge clk) disable iff (rst)
        (push_i && $past(!rst)) ##1 (pop_i && !push_i) |=> top_o == $past(push_addr_i, 2));

    // R5
    a_r5_idle_holds: assert property (@(posedge clk) disable iff (rst)
        (!push_i && !pop_i) |=> $stable(top_o) && $stable(ptr));

endmodule

bind callret_stack callret_stack_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .push_i      (push_i),
    .push_addr_i (push_addr_i),
    .pop_i       (pop_i),
    .top_o       (top_o),
    .ptr         (ptr_q)
);

// File: tb/test_callret_stack.sv
module test_callret_stack;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        push_i = 1'b0;
    logic        pop_i = 1'b0;
    logic [12:0] push_addr_i = '0;
    logic [12:0] top_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    callret_stack i_callret_stack (
        .clk         (clk),
        .rst         (rst),
        .push_i      (push_i),
        .push_addr_i (push_addr_i),
        .pop_i       (pop_i),
        .top_o       (top_o)
    );

    // Row layout: [27] push, [26] pop, [25:13] address, [12:0] expected top_o
    localparam int NVEC = 10;
    localparam logic [27:0] VEC [NVEC] = '{
        {1'b1, 1'b0, 13'h0100, 13'h0100},  // R2 push
        {1'b1, 1'b0, 13'h00A5, 13'h00A5},  // R2 push
        {1'b0, 1'b0, 13'h1234, 13'h00A5},  // R5 idle, address ignored
        {1'b0, 1'b1, 13'h0000, 13'h00A5},  // R3 pop returns latest
        {1'b0, 1'b1, 13'h0000, 13'h0100},  // R3 pop returns older
        {1'b1, 1'b0, 13'h1FFF, 13'h1FFF},  // R2 push all ones
        {1'b1, 1'b1, 13'h0123, 13'h0123},  // R6 both: push wins
        {1'b0, 1'b1, 13'h0000, 13'h0123},  // R6 pop sees that push
        {1'b0, 1'b1, 13'h0000, 13'h1FFF},  // R3
        {1'b0, 1'b0, 13'h0000, 13'h1FFF}   // R5 idle hold
    };

    task automatic check(input string req, input logic [12:0] exp);
        n_chk++;
        if (top_o !== exp) begin
            n_bad++;
            $display("FAIL %s: top_o=%h expected %h", req, top_o, exp);
        end
    endtask

    task automatic step(input logic pu, input logic po, input logic [12:0] a);
        push_i = pu;
        pop_i = po;
        push_addr_i = a;
        @(negedge clk);
        push_i = 1'b0;
        pop_i = 1'b0;
    endtask

    function automatic logic [12:0] wval(input int i);
        return 13'h0400 + 13'(i * 19);
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        check("R1", 13'h0000);
        rst = 1'b0;

        for (int v = 0; v < NVEC; v++) begin
            step(VEC[v][27], VEC[v][26], VEC[v][25:13]);
            check($sformatf("vector %0d", v), VEC[v][12:0]);
        end

        // Reset so the pointer starts at slot 0, then overrun the stack.
        rst = 1'b1;
        @(negedge clk);
        check("R1", 13'h0000);
        rst = 1'b0;
        for (int i = 0; i < 9; i++) begin
            step(1'b1, 1'b0, wval(i));
            check("R2", wval(i));
        end
        for (int k = 0; k < 8; k++) begin
            step(1'b0, 1'b1, '0);
            check("R4", wval(8 - k));
        end
        step(1'b0, 1'b1, '0);
        check("R4", wval(8));
        step(1'b0, 1'b0, 13'h0777);
        check("R5", wval(8));

        // Slot 7 holds wval(7); reset keeps it.
        rst = 1'b1;
        @(negedge clk);
        check("R1", 13'h0000);
        rst = 1'b0;
        step(1'b0, 1'b1, '0);
        check("R7", wval(7));

        // Pointer at 7: push and pop together, then pop back.
        step(1'b1, 1'b1, 13'h0ABC);
        check("R6", 13'h0ABC);
        step(1'b0, 1'b1, '0);
        check("R6", 13'h0ABC);

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run stalled, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule